// File: doc/BRIEF.md
# Four-Phase Pipelined Execute Datapath

This block executes one register-to-register or load instruction per instruction cycle, where every instruction cycle is four fast clocks long. A two-bit phase counter names the four sub-cycles. Each one has a fixed duty. Phase 0 reads the two sources, with bypass. Phase 1 shifts the second operand. Phase 2 runs the ALU and commits the earlier result. Phase 3 aligns load data and captures the next decoded instruction.

Three instructions overlap at any time. While one instruction executes, the instruction before it is being committed and the one after it is being decoded. A result is first held in a pending-result register. It is written to the register file during the phase-2 sub-cycle of the following instruction, and the condition flags are committed at the same time. A source that names the destination of the immediately preceding writing instruction is taken from the pending-result register. As a result, software sees plain sequential semantics.

The surrounding logic works as follows. It presents a decoded instruction and holds it across the clock in which `phase_o` reads 3. It supplies load data, which is sampled at the phase-2 edge of the same instruction. It observes the register file and the flags through the flat outputs.

Top module: `quad_phase_dp`

## Requirements
- R1: `phase_o` is 0 after reset and advances 0,1,2,3,0 on every clock. `phi1_o` is high exactly while `phase_o` is 0.
- R2: The instruction inputs are captured at the clock edge where `phase_o` is 3. If `in_valid` is low there, a no-op is executed instead, which changes no register and no flag.
- R3: The ALU computes `A op (B << in_shamt)`, where A is source 1 and B is source 2. The `in_alu_op` codes are: 0 add, 1 A-B, 2 and, 3 or, 4 xor, 5 pass shifted B, 6 shifted-B minus A, 7 A and not B.
- R4: An instruction captured at edge t writes its destination at edge t+7, which is the phase-2 edge of the next instruction. Before that edge the register keeps its old value.
- R5: A source equal to the previous instruction's destination receives that instruction's result, whether the source is in slot 1 or slot 2. Results from two instructions back are read from the register file.
- R6: An instruction with `in_we` low writes nothing. It is never forwarded to the next instruction, even if its destination index matches a source.
- R7: Register 0 always reads as zero. Writes to it are discarded, including through the bypass path.
- R8: `psw_o` is {Z,N,C,V} with Z at bit 3 and V at bit 0. Z means the result is zero and N is the result's top bit. For add, C is the carry out. For the two subtract codes, C is the borrow. V is signed overflow for add and subtract, and C and V are 0 for logic ops. The flags are written only by instructions with `in_scc` high, and they are committed with the same one-instruction delay as R4.
- R9: With `in_load` high, the result is built from `ld_data` using the low two bits of the ALU sum as a byte lane. `in_ld_kind` 0 loads the full word. Kind 1 zero-extends the half selected by lane bit 1. Kind 2 zero-extends the selected byte, and kind 3 sign-extends it. For a load, Z and N follow the loaded value and C=V=0.
- R10: While `rst_n` is low, all registers and flags read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast clock, four per instruction |
| rst_n | input | 1 | synchronous active-low reset |
| in_valid | input | 1 | decoded instruction present at the phase-3 edge |
| in_rs1 | input | $clog2(NREGS) | source 1 index |
| in_rs2 | input | $clog2(NREGS) | source 2 index |
| in_rd | input | $clog2(NREGS) | destination index |
| in_alu_op | input | 3 | ALU operation code |
| in_shamt | input | $clog2(XLEN) | left shift applied to source 2 |
| in_we | input | 1 | instruction writes its destination |
| in_scc | input | 1 | instruction updates the flags |
| in_load | input | 1 | instruction is a load |
| in_ld_kind | input | 2 | load width and extension |
| ld_data | input | XLEN | load data, sampled at the phase-2 edge |
| phase_o | output | 2 | current sub-cycle |
| phi1_o | output | 1 | high during sub-cycle 0 |
| regs_o | output | NREGS*XLEN | register file, register i at bits i*XLEN upward |
| psw_o | output | 4 | committed flags {Z,N,C,V} |

## Verification
The bench builds the block with XLEN=32 and NREGS=4. This configuration is small enough to sweep every ALU code against every pair from a set of six boundary operands, with shift amounts of 0 to 4. The order of the operand-preparing loads alternates, so that forwarding into each source slot is covered. Four registers are enough for an operation to read two freshly written sources and write a third. Loads at all four byte lanes, with all four load kinds and two data patterns, cover the alignment paths and the load flags.

// File: rtl/qpd_pkg.sv
// Shared types for the four-phase datapath: ALU codes, load kinds, flag word.
package qpd_pkg;
    typedef enum logic [2:0] {
        ALU_ADD  = 3'd0,
        ALU_SUB  = 3'd1,
        ALU_AND  = 3'd2,
        ALU_OR   = 3'd3,
        ALU_XOR  = 3'd4,
        ALU_PASSB = 3'd5,
        ALU_RSUB = 3'd6,
        ALU_ANDN = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        LD_WORD  = 2'd0,
        LD_HALF  = 2'd1,
        LD_BYTE  = 2'd2,
        LD_SBYTE = 2'd3
    } ld_kind_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } flags_t;
endpackage

// File: rtl/qpd_phase_ctr.sv
// Sub-cycle sequencer: counts 0..3 once per fast clock and wraps.
// Assumes nothing about the instruction stream; phase 0 follows reset.
module qpd_phase_ctr (
    input  logic       clk,
    input  logic       rst_n,
    output logic [1:0] phase_o,
    output logic       phi1_o
);
    logic [1:0] cnt_q;

    // Advance the phase every clock, wrapping naturally at 2 bits.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= 2'd0;
        else        cnt_q <= cnt_q + 2'd1;
    end

    assign phase_o = cnt_q;
    assign phi1_o  = (cnt_q == 2'd0);
endmodule

// File: rtl/qpd_regfile.sv
// Register file with two combinational read ports and one write port.
// Entry 0 is never written and so always reads zero. Whole file exposed flat.
module qpd_regfile #(
    parameter int XLEN  = 32,
    parameter int NREGS = 8,
    localparam int IW   = $clog2(NREGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IW-1:0]         wr_idx,
    input  logic [XLEN-1:0]       wr_val,
    input  logic [IW-1:0]         rd_idx_a,
    input  logic [IW-1:0]         rd_idx_b,
    output logic [XLEN-1:0]       rd_val_a,
    output logic [XLEN-1:0]       rd_val_b,
    output logic [NREGS*XLEN-1:0] flat_o
);
    logic [NREGS-1:0][XLEN-1:0] mem_q;

    // Store the write unless it targets entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else if (wr_en && (wr_idx != '0)) mem_q[wr_idx] <= wr_val;
    end

    assign rd_val_a = mem_q[rd_idx_a];
    assign rd_val_b = mem_q[rd_idx_b];

    for (genvar i = 0; i < NREGS; i++) begin : g_flat
        assign flat_o[i*XLEN +: XLEN] = mem_q[i];
    end
endmodule

// File: rtl/qpd_alu.sv
// Combinational ALU with zero/negative/carry/overflow flags.
// Subtract codes report borrow in the carry flag; logic codes clear C and V.
module qpd_alu
    import qpd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y,
    output flags_t          flags
);
    localparam int MSB = XLEN - 1;
    logic [XLEN:0] sum_w;

    // Select the result and the carry/overflow for the operation code.
    always_comb begin
        sum_w   = '0;
        y       = '0;
        flags.c = 1'b0;
        flags.v = 1'b0;
        case (op)
            ALU_ADD: begin
                sum_w   = {1'b0, a} + {1'b0, b};
                y       = sum_w[MSB:0];
                flags.c = sum_w[XLEN];
                flags.v = (a[MSB] == b[MSB]) && (y[MSB] != a[MSB]);
            end
            ALU_SUB: begin
                sum_w   = {1'b0, a} - {1'b0, b};
                y       = sum_w[MSB:0];
                flags.c = sum_w[XLEN];
                flags.v = (a[MSB] != b[MSB]) && (y[MSB] != a[MSB]);
            end
            ALU_RSUB: begin
                sum_w   = {1'b0, b} - {1'b0, a};
                y       = sum_w[MSB:0];
                flags.c = sum_w[XLEN];
                flags.v = (a[MSB] != b[MSB]) && (y[MSB] != b[MSB]);
            end
            ALU_AND:   y = a & b;
            ALU_OR:    y = a | b;
            ALU_XOR:   y = a ^ b;
            ALU_PASSB: y = b;
            ALU_ANDN:  y = a & ~b;
            default:   y = '0;
        endcase
        flags.z = (y == '0);
        flags.n = y[MSB];
    end
endmodule

// File: rtl/qpd_load_align.sv
// Extracts a word, half or byte from load data by byte lane and extends it.
// Assumes XLEN >= 32; lanes address the low 32 bits.
module qpd_load_align
    import qpd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  ld_kind_e        kind,
    input  logic [1:0]      lane,
    input  logic [XLEN-1:0] data,
    output logic [XLEN-1:0] y
);
    logic [XLEN-1:0] half_sh;
    logic [XLEN-1:0] byte_sh;

    assign half_sh = data >> {lane[1], 4'b0000};
    assign byte_sh = data >> {lane, 3'b000};

    // Pick the width and extension of the loaded value.
    always_comb begin
        case (kind)
            LD_WORD:  y = data;
            LD_HALF:  y = {{(XLEN-16){1'b0}}, half_sh[15:0]};
            LD_BYTE:  y = {{(XLEN-8){1'b0}}, byte_sh[7:0]};
            default:  y = {{(XLEN-8){byte_sh[7]}}, byte_sh[7:0]};
        endcase
    end
endmodule

// File: rtl/quad_phase_dp.sv
// Four-phase execute datapath. Phase 3 captures the decoded instruction.
// Phase 0 reads operands with bypass from the pending-result register.
// Phase 1 shifts operand B. Phase 2 computes, and commits the previous
// instruction's result and flags. Phase 3 also aligns load data.
// Assumes decoded fields are stable across the phase-3 edge and ld_data across the phase-2 edge.
module quad_phase_dp
    import qpd_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NREGS = 8,
    localparam int IW   = $clog2(NREGS),
    localparam int SW   = $clog2(XLEN)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [IW-1:0]         in_rs1,
    input  logic [IW-1:0]         in_rs2,
    input  logic [IW-1:0]         in_rd,
    input  logic [2:0]            in_alu_op,
    input  logic [SW-1:0]         in_shamt,
    input  logic                  in_we,
    input  logic                  in_scc,
    input  logic                  in_load,
    input  logic [1:0]            in_ld_kind,
    input  logic [XLEN-1:0]       ld_data,
    output logic [1:0]            phase_o,
    output logic                  phi1_o,
    output logic [NREGS*XLEN-1:0] regs_o,
    output logic [3:0]            psw_o
);
    typedef struct packed {
        logic [IW-1:0] rs1;
        logic [IW-1:0] rs2;
        logic [IW-1:0] rd;
        logic [2:0]    op;
        logic [SW-1:0] shamt;
        logic          we;
        logic          scc;
        logic          ld;
        logic [1:0]    ldk;
    } ctl_t;

    localparam logic [1:0] PH_READ  = 2'd0;
    localparam logic [1:0] PH_SHIFT = 2'd1;
    localparam logic [1:0] PH_EXEC  = 2'd2;
    localparam logic [1:0] PH_ALIGN = 2'd3;

    logic [1:0]      phase;
    ctl_t            dec_w, cur_q, prv_q;
    logic [XLEN-1:0] rf_a, rf_b, opa_q, opb_q, shb_q, dlat_q, ldd_q;
    logic [XLEN-1:0] alu_y, ld_y;
    flags_t          alu_f, pend_q, psw_q;
    logic            hit_a, hit_b, commit_w;

    qpd_phase_ctr u_ph (
        .clk(clk), .rst_n(rst_n), .phase_o(phase), .phi1_o(phi1_o)
    );

    // Invalid slots become no-ops: nothing written, no flags.
    always_comb begin
        dec_w = '0;
        if (in_valid) begin
            dec_w.rs1   = in_rs1;
            dec_w.rs2   = in_rs2;
            dec_w.rd    = in_rd;
            dec_w.op    = in_alu_op;
            dec_w.shamt = in_shamt;
            dec_w.we    = in_we;
            dec_w.scc   = in_scc;
            dec_w.ld    = in_load;
            dec_w.ldk   = in_ld_kind;
        end
    end

    // Decode register: capture the next instruction at the phase-3 edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                cur_q <= '0;
        else if (phase == PH_ALIGN) cur_q <= dec_w;
    end

    assign commit_w = (phase == PH_EXEC) && prv_q.we && (prv_q.rd != '0);

    qpd_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(commit_w), .wr_idx(prv_q.rd), .wr_val(dlat_q),
        .rd_idx_a(cur_q.rs1), .rd_idx_b(cur_q.rs2),
        .rd_val_a(rf_a), .rd_val_b(rf_b), .flat_o(regs_o)
    );

    // Bypass only from a previous instruction that really writes a nonzero index.
    assign hit_a = prv_q.we && (prv_q.rd != '0) && (prv_q.rd == cur_q.rs1);
    assign hit_b = prv_q.we && (prv_q.rd != '0) && (prv_q.rd == cur_q.rs2);

    // Phase 0 read and phase 1 shift of the operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opa_q <= '0;
            opb_q <= '0;
            shb_q <= '0;
        end else if (phase == PH_READ) begin
            opa_q <= hit_a ? dlat_q : rf_a;
            opb_q <= hit_b ? dlat_q : rf_b;
        end else if (phase == PH_SHIFT) begin
            shb_q <= opb_q << cur_q.shamt;
        end
    end

    qpd_alu #(.XLEN(XLEN)) u_alu (
        .op(alu_op_e'(cur_q.op)), .a(opa_q), .b(shb_q), .y(alu_y), .flags(alu_f)
    );

    qpd_load_align #(.XLEN(XLEN)) u_ld (
        .kind(ld_kind_e'(prv_q.ldk)), .lane(dlat_q[1:0]), .data(ldd_q), .y(ld_y)
    );

    // Phase 2 fills the pending-result register; phase 3 overwrites it for loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dlat_q <= '0;
            pend_q <= '0;
            ldd_q  <= '0;
            prv_q  <= '0;
        end else if (phase == PH_EXEC) begin
            dlat_q <= alu_y;
            pend_q <= alu_f;
            ldd_q  <= ld_data;
            prv_q  <= cur_q;
        end else if ((phase == PH_ALIGN) && prv_q.ld) begin
            dlat_q <= ld_y;
            pend_q <= '{z: (ld_y == '0), n: ld_y[XLEN-1], c: 1'b0, v: 1'b0};
        end
    end

    // Commit the previous instruction's flags at phase 2 when it asked to.
    always_ff @(posedge clk) begin
        if (!rst_n)                              psw_q <= '0;
        else if ((phase == PH_EXEC) && prv_q.scc) psw_q <= pend_q;
    end

    assign phase_o = phase;
    assign psw_o   = psw_q;
endmodule

// File: rtl/qpd_checker.sv
// Timing properties of the four-phase datapath, observed at its ports.
module qpd_checker #(
    parameter int XLEN  = 32,
    parameter int NREGS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [1:0]            phase_o,
    input logic                  phi1_o,
    input logic [NREGS*XLEN-1:0] regs_o,
    input logic [3:0]            psw_o
);
    a_r1_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (phase_o == $past(phase_o) + 2'd1));

    a_r1_strobe_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phi1_o) |-> ($past(phase_o) == 2'd3));

    a_r4_rf_changes_in_exec: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_o) |-> ($past(phase_o) == 2'd2));

    a_r8_flags_change_in_exec: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(psw_o) |-> ($past(phase_o) == 2'd2));

    // R7: register 0 reads zero at every sampled edge
    always @(posedge clk) begin
        if (rst_n) a_r7_zero_reg: assert (regs_o[XLEN-1:0] == '0);
    end
endmodule

bind quad_phase_dp qpd_checker #(.XLEN(XLEN), .NREGS(NREGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .phase_o(phase_o), .phi1_o(phi1_o),
    .regs_o(regs_o), .psw_o(psw_o)
);

// File: tb/sim_quad_phase_dp.sv
`timescale 1ns/1ps
module sim_quad_phase_dp;
    localparam int XLEN  = 32;
    localparam int NREGS = 4;
    localparam int IW    = 2;
    localparam int SW    = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [IW-1:0] in_rs1 = '0, in_rs2 = '0, in_rd = '0;
    logic [2:0] in_alu_op = '0;
    logic [SW-1:0] in_shamt = '0;
    logic in_we = 1'b0, in_scc = 1'b0, in_load = 1'b0;
    logic [1:0] in_ld_kind = '0;
    logic [XLEN-1:0] ld_data = '0;
    logic [1:0] phase_o;
    logic phi1_o;
    logic [NREGS*XLEN-1:0] regs_o;
    logic [3:0] psw_o;

    int total = 0;
    int bad = 0;
    logic [31:0] mrf [NREGS];
    logic [3:0] mpsw;

    always #2.5 clk = ~clk;

    quad_phase_dp #(.XLEN(XLEN), .NREGS(NREGS)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_rs1(in_rs1),
        .in_rs2(in_rs2), .in_rd(in_rd), .in_alu_op(in_alu_op), .in_shamt(in_shamt),
        .in_we(in_we), .in_scc(in_scc), .in_load(in_load), .in_ld_kind(in_ld_kind),
        .ld_data(ld_data), .phase_o(phase_o), .phi1_o(phi1_o), .regs_o(regs_o),
        .psw_o(psw_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [35:0] m_alu(input int op, input logic [31:0] a, input logic [31:0] b);
        logic [32:0] s;
        logic [31:0] y;
        logic c, v;
        s = '0; y = '0; c = 1'b0; v = 1'b0;
        case (op)
            0: begin s = {1'b0, a} + {1'b0, b}; y = s[31:0]; c = s[32];
                     v = (a[31] == b[31]) && (y[31] != a[31]); end
            1: begin s = {1'b0, a} - {1'b0, b}; y = s[31:0]; c = s[32];
                     v = (a[31] != b[31]) && (y[31] != a[31]); end
            2: y = a & b;
            3: y = a | b;
            4: y = a ^ b;
            5: y = b;
            6: begin s = {1'b0, b} - {1'b0, a}; y = s[31:0]; c = s[32];
                     v = (a[31] != b[31]) && (y[31] != b[31]); end
            default: y = a & ~b;
        endcase
        return {(y == 32'd0), y[31], c, v, y};
    endfunction

    function automatic logic [31:0] m_ld(input int kind, input logic [31:0] d, input logic [1:0] lane);
        logic [7:0] bt;
        bt = d[8*lane +: 8];
        case (kind)
            0: return d;
            1: return lane[1] ? {16'd0, d[31:16]} : {16'd0, d[15:0]};
            2: return {24'd0, bt};
            default: return {{24{bt[7]}}, bt};
        endcase
    endfunction

    // Present one instruction for the coming phase-3 edge and update the model.
    task automatic issue(input logic v, input int rs1, input int rs2, input int rd,
                         input int op, input int sh, input logic we, input logic scc,
                         input logic ld, input int ldk, input logic [31:0] ldv);
        logic [35:0] r;
        logic [31:0] y;
        logic [3:0] f;
        do @(negedge clk); while (phase_o != 2'd3);
        in_valid = v; in_rs1 = rs1[IW-1:0]; in_rs2 = rs2[IW-1:0]; in_rd = rd[IW-1:0];
        in_alu_op = op[2:0]; in_shamt = sh[SW-1:0]; in_we = we; in_scc = scc;
        in_load = ld; in_ld_kind = ldk[1:0]; ld_data = ldv;
        if (v) begin
            r = m_alu(op, mrf[rs1], mrf[rs2] << sh);
            y = r[31:0];
            f = r[35:32];
            if (ld) begin
                y = m_ld(ldk, ldv, y[1:0]);
                f = {(y == 32'd0), y[31], 2'b00};
            end
            if (we && rd != 0) mrf[rd] = y;
            if (scc) mpsw = f;
        end
    endtask

    task automatic ldw(input int rd, input logic [31:0] val);
        issue(1'b1, 0, 0, rd, 0, 0, 1'b1, 1'b0, 1'b1, 0, val);
    endtask

    task automatic drain();
        issue(1'b0, 0, 0, 0, 0, 0, 1'b0, 1'b0, 1'b0, 0, 32'd0);
        issue(1'b0, 0, 0, 0, 0, 0, 1'b0, 1'b0, 1'b0, 0, 32'd0);
    endtask

    function automatic logic [31:0] rv(input int i);
        return regs_o[i*XLEN +: XLEN];
    endfunction

    logic [31:0] vals [6] = '{32'h0, 32'h1, 32'h7fffffff, 32'h80000000, 32'hffffffff, 32'h12345678};
    logic [31:0] ldpat [2] = '{32'hA1F27E83, 32'h00000000};

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [1:0] prev_ph;
        for (int i = 0; i < NREGS; i++) mrf[i] = 32'd0;
        mpsw = 4'd0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < NREGS; i++) chk("R10 reset register", rv(i), 32'd0);
        chk("R10 reset flags", {28'd0, psw_o}, 32'd0);
        chk("R1 reset phase", {30'd0, phase_o}, 32'd0);
        chk("R1 reset strobe", {31'd0, phi1_o}, 32'd1);
        rst_n = 1'b1;
        prev_ph = phase_o;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R1 phase step", {30'd0, phase_o}, {30'd0, prev_ph + 2'd1});
            chk("R1 strobe", {31'd0, phi1_o}, {31'd0, phase_o == 2'd0});
            prev_ph = phase_o;
        end

        // R3 R5 R8: all codes over boundary operands, alternating which slot is forwarded
        for (int op = 0; op < 8; op++) begin
            for (int i = 0; i < 6; i++) begin
                for (int j = 0; j < 6; j++) begin
                    if (((i + j) % 2) == 0) begin ldw(1, vals[i]); ldw(2, vals[j]); end
                    else begin ldw(2, vals[j]); ldw(1, vals[i]); end
                    issue(1'b1, 1, 2, 3, op, (i + 2*j) % 5, 1'b1, 1'b1, 1'b0, 0, 32'd0);
                    drain();
                    chk("R3 R5 result", rv(3), mrf[3]);
                    chk("R8 flags", {28'd0, psw_o}, {28'd0, mpsw});
                end
            end
        end

        // R5: back-to-back dependent chain
        ldw(1, 32'h00000015);
        issue(1'b1, 1, 1, 2, 0, 0, 1'b1, 1'b0, 1'b0, 0, 32'd0);
        issue(1'b1, 2, 1, 3, 1, 1, 1'b1, 1'b1, 1'b0, 0, 32'd0);
        drain();
        chk("R5 chain r2", rv(2), 32'h0000002A);
        chk("R5 chain r3", rv(3), mrf[3]);

        // R8: no flag update without the set-condition bit
        ldw(1, 32'h80000000);
        issue(1'b1, 1, 1, 2, 0, 0, 1'b1, 1'b1, 1'b0, 0, 32'd0);
        issue(1'b1, 0, 0, 3, 0, 0, 1'b1, 1'b0, 1'b0, 0, 32'd0);
        drain();
        chk("R8 flags set", {28'd0, psw_o}, 32'h0000000B);
        chk("R8 flags held", {28'd0, psw_o}, {28'd0, mpsw});

        // R6: non-writing instruction with matching index is not forwarded
        ldw(1, 32'd55);
        issue(1'b1, 1, 1, 1, 0, 0, 1'b0, 1'b0, 1'b0, 0, 32'd0);
        issue(1'b1, 0, 1, 2, 5, 0, 1'b1, 1'b0, 1'b0, 0, 32'd0);
        drain();
        chk("R6 no forward", rv(2), 32'd55);
        chk("R6 no write", rv(1), 32'd55);

        // R7: writes to register 0 vanish, also on the bypass path
        issue(1'b1, 1, 1, 0, 0, 0, 1'b1, 1'b0, 1'b0, 0, 32'd0);
        issue(1'b1, 0, 0, 2, 5, 0, 1'b1, 1'b0, 1'b0, 0, 32'd0);
        drain();
        chk("R7 zero reg", rv(0), 32'd0);
        chk("R7 zero bypass", rv(2), 32'd0);

        // R2: invalid slot has no effect even with write and flag bits set
        ldw(1, 32'd9);
        drain();
        issue(1'b0, 1, 1, 1, 1, 0, 1'b1, 1'b1, 1'b0, 0, 32'd0);
        drain();
        chk("R2 bubble reg", rv(1), 32'd9);
        chk("R2 bubble flags", {28'd0, psw_o}, {28'd0, mpsw});

        // R4: write lands at the phase-2 edge of the following instruction
        ldw(1, 32'd0);
        drain();
        ldw(1, 32'h00000011);
        issue(1'b0, 0, 0, 0, 0, 0, 1'b0, 1'b0, 1'b0, 0, 32'd0);
        repeat (3) @(negedge clk);
        chk("R4 before commit", rv(1), 32'd0);
        @(negedge clk);
        chk("R4 after commit", rv(1), 32'h00000011);

        // R9: every load kind at every lane, two data patterns
        for (int p = 0; p < 2; p++) begin
            for (int kind = 0; kind < 4; kind++) begin
                for (int lane = 0; lane < 4; lane++) begin
                    ldw(1, lane);
                    issue(1'b1, 1, 0, 3, 0, 0, 1'b1, 1'b1, 1'b1, kind, ldpat[p]);
                    drain();
                    chk("R9 load value", rv(3), mrf[3]);
                    chk("R9 load flags", {28'd0, psw_o}, {28'd0, mpsw});
                end
            end
        end

        drain();
        for (int i = 0; i < NREGS; i++) chk("R4 final file", rv(i), mrf[i]);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule